// File: doc/BRIEF.md
# Interrupt Pending Aggregator

This block collects every interrupt request in a peripheral cluster into one pending word and drives the single request line toward the host. There are two kinds of source. Four GPIO bank summary lines arrive already reduced inside their banks and appear live in the status word. Six further peripheral event inputs are captured into sticky pending bits, and software clears those bits by writing a 1 to them.

A mask word holds one enable bit for each peripheral source, where 1 means enabled, and a global enable bit that gates the host line for every source. The host detects the line on its rising edge. For that reason a small state machine forces a one-cycle low gap whenever a new enabled source appears while the line is already high. Software reaches both words through a 16-bit read/write port with a two-bit address.

Output state machine:
- States: `ST_IDLE` (line low), `ST_RAISED` (line high), `ST_REARM` (a one-cycle low gap).
- `ST_IDLE -> ST_RAISED` when any enabled condition is active.
- `ST_RAISED -> ST_IDLE` when nothing enabled remains active.
- `ST_RAISED -> ST_REARM` when an enabled bit becomes active that was not active in the previous cycle.
- `ST_REARM -> ST_RAISED` if something is still active, otherwise `ST_REARM -> ST_IDLE`.

Top module: `intc_pending_gate`

## Requirements
- R1: A read at address 0 returns the status word. Bits 3:0 are bank lines 0 to 3 in that order. Bits 9:4 are the pending bits of peripheral sources 0 to 5 in ascending order. Bits 15:10 read 0. Zero in bits 9:0 means nothing is pending.
- R2: The bank bits follow the bank inputs with no latching. Writes to status bits 3:0 have no effect.
- R3: A peripheral input that is high at a clock edge sets its pending bit at that edge. The bit stays set until software writes 1 to it at address 0. Writing 0 to the bit leaves it unchanged.
- R4: If a source event and a write-1-to-clear of the same bit happen in the same cycle, the bit ends up set.
- R5: Address 1 is the mask word. Bits 9:4 enable peripheral sources 0 to 5 (1 = enabled), and bit 15 is the global enable. All other bits read 0.
- R6: A masked source still sets its status bit but does not drive the host line. Bank lines are gated only by the global enable.
- R7: When the global enable is cleared, or when nothing enabled is active, the host line goes low at the next clock edge.
- R8: From `ST_IDLE`, the host line rises at the first edge after an enabled condition becomes visible. For a peripheral event this is the second edge after the event is sampled.
- R9: While the line is high, a newly active enabled bit makes the line low for exactly one cycle, and then the line goes high again.
- R10: After reset, the host line is low and the pending bits, the source enables and the global enable are all cleared.
- R11: Addresses 2 and 3 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bank_irq_i | input | 4 | Live summary lines of the GPIO banks |
| src_irq_i | input | 6 | Peripheral event inputs, sampled on every edge |
| reg_addr_i | input | 2 | Register address (0 = status, 1 = mask) |
| reg_wr_i | input | 1 | Write strobe, one cycle per write |
| reg_wdata_i | input | 16 | Write data |
| reg_rdata_o | output | 16 | Read data for `reg_addr_i`, combinational |
| host_irq_o | output | 1 | Interrupt request to the host |

## Verification
Two functions can fall in the same cycle. One is the capture of a peripheral event and the other is a software write-1-to-clear of the same pending bit. The bench drives both in one cycle and expects the bit to read back set. Only a later clear with no event removes it. The re-arm path is similar: a second source arrives while the line is high. It is judged edge by edge, and the line must read high, then low, then high on three consecutive cycles.

// File: rtl/intc_agg_pkg.sv
package intc_agg_pkg;
    localparam int REG_W = 16;
    localparam int ADDR_W = 2;
    localparam logic [ADDR_W-1:0] ADDR_STATUS = 2'd0;
    localparam logic [ADDR_W-1:0] ADDR_MASK   = 2'd1;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_RAISED = 2'd1,
        ST_REARM  = 2'd2
    } irq_state_e;
endpackage

// File: rtl/intc_src_pending.sv
module intc_src_pending #(
    parameter int NUM_SRC = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] src_i,
    input  logic [NUM_SRC-1:0] clr_i,
    output logic [NUM_SRC-1:0] pend_o
);
    logic [NUM_SRC-1:0] pend_q;

    for (genvar k = 0; k < NUM_SRC; k++) begin : g_bit
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                pend_q[k] <= 1'b0;
            else if (src_i[k])
                pend_q[k] <= 1'b1;
            else if (clr_i[k])
                pend_q[k] <= 1'b0;
        end
    end

    assign pend_o = pend_q;

    // R3
    event_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|src_i) |=> ((pend_q & $past(src_i)) == $past(src_i)));

    // R3
    sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (|(pend_q & ~clr_i)) |=> ((pend_q & $past(pend_q & ~clr_i)) == $past(pend_q & ~clr_i)));
endmodule

// File: rtl/intc_mask_reg.sv
module intc_mask_reg #(
    parameter int NUM_SRC = 6,
    parameter int REG_W   = 16,
    parameter int SRC_LSB = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_i,
    input  logic [REG_W-1:0]   wdata_i,
    output logic [NUM_SRC-1:0] en_o,
    output logic               glb_o
);
    localparam int GEN_BIT = REG_W - 1;

    logic [NUM_SRC-1:0] en_q;
    logic               glb_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q  <= '0;
            glb_q <= 1'b0;
        end else if (wr_i) begin
            en_q  <= wdata_i[SRC_LSB +: NUM_SRC];
            glb_q <= wdata_i[GEN_BIT];
        end
    end

    assign en_o  = en_q;
    assign glb_o = glb_q;

    // R5
    mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_i |=> (glb_o == $past(wdata_i[GEN_BIT])));
endmodule

// File: rtl/intc_irq_fsm.sv
module intc_irq_fsm
    import intc_agg_pkg::*;
#(
    parameter int EFF_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [EFF_W-1:0] eff_i,
    output logic             irq_o
);
    irq_state_e       state, state_nx;
    logic [EFF_W-1:0] eff_prev;
    logic             any_act, fresh;

    assign any_act = |eff_i;
    assign fresh   = |(eff_i & ~eff_prev);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            eff_prev <= '0;
        end else begin
            state    <= state_nx;
            eff_prev <= eff_i;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:   if (any_act) state_nx = ST_RAISED;
            ST_RAISED: begin
                if (!any_act)   state_nx = ST_IDLE;
                else if (fresh) state_nx = ST_REARM;
            end
            ST_REARM:  state_nx = any_act ? ST_RAISED : ST_IDLE;
            default:   state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        irq_o = (state == ST_RAISED);
    end

    // R9
    rearm_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REARM) |=> (state != ST_REARM));

    // R9
    fresh_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_o && fresh) |=> !irq_o);

    // R7
    no_active_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !any_act |=> !irq_o);

    // R8
    raise_from_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_IDLE && any_act) |=> irq_o);
endmodule

// File: rtl/intc_pending_gate.sv
module intc_pending_gate
    import intc_agg_pkg::*;
#(
    parameter int NUM_BANKS = 4,
    parameter int NUM_SRC   = 6
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_BANKS-1:0] bank_irq_i,
    input  logic [NUM_SRC-1:0]   src_irq_i,
    input  logic [ADDR_W-1:0]    reg_addr_i,
    input  logic                 reg_wr_i,
    input  logic [REG_W-1:0]     reg_wdata_i,
    output logic [REG_W-1:0]     reg_rdata_o,
    output logic                 host_irq_o
);
    localparam int SRC_LSB = NUM_BANKS;
    localparam int STAT_W  = NUM_BANKS + NUM_SRC;
    localparam int GEN_BIT = REG_W - 1;

    logic               wr_status, wr_mask;
    logic [NUM_SRC-1:0] clr_vec, pend, src_en;
    logic               glb_en;
    logic [STAT_W-1:0]  status_w, eff_w;

    assign wr_status = reg_wr_i && (reg_addr_i == ADDR_STATUS);
    assign wr_mask   = reg_wr_i && (reg_addr_i == ADDR_MASK);
    assign clr_vec   = wr_status ? reg_wdata_i[SRC_LSB +: NUM_SRC] : '0;

    intc_src_pending #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk    (clk),
        .rst_n  (rst_n),
        .src_i  (src_irq_i),
        .clr_i  (clr_vec),
        .pend_o (pend)
    );

    intc_mask_reg #(.NUM_SRC(NUM_SRC), .REG_W(REG_W), .SRC_LSB(SRC_LSB)) u_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_i    (wr_mask),
        .wdata_i (reg_wdata_i),
        .en_o    (src_en),
        .glb_o   (glb_en)
    );

    assign status_w = {pend, bank_irq_i};
    assign eff_w    = glb_en ? {pend & src_en, bank_irq_i} : '0;

    intc_irq_fsm #(.EFF_W(STAT_W)) u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .eff_i (eff_w),
        .irq_o (host_irq_o)
    );

    always_comb begin
        reg_rdata_o = '0;
        unique case (reg_addr_i)
            ADDR_STATUS: reg_rdata_o[STAT_W-1:0] = status_w;
            ADDR_MASK: begin
                reg_rdata_o[SRC_LSB +: NUM_SRC] = src_en;
                reg_rdata_o[GEN_BIT]            = glb_en;
            end
            default: reg_rdata_o = '0;
        endcase
    end

    // R6
    global_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !glb_en |=> !host_irq_o);
endmodule

// File: tb/intc_pending_gate_test.sv
module intc_pending_gate_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  bank = '0;
    logic [5:0]  src = '0;
    logic [1:0]  addr = '0;
    logic        wr = 1'b0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;
    int          n_run = 0;
    int          n_fail = 0;

    always #4 clk = ~clk;

    intc_pending_gate uut (
        .clk(clk), .rst_n(rst_n), .bank_irq_i(bank), .src_irq_i(src),
        .reg_addr_i(addr), .reg_wr_i(wr), .reg_wdata_i(wdata),
        .reg_rdata_o(rdata), .host_irq_o(irq)
    );

    // {bank[3:0], src[5:0], mask[15:0], irq}
    localparam logic [26:0] VEC [9] = '{
        {4'h0, 6'h00, 16'h8000, 1'b0},
        {4'h1, 6'h00, 16'h8000, 1'b1},
        {4'h0, 6'h01, 16'h8010, 1'b1},
        {4'h0, 6'h01, 16'h8020, 1'b0},
        {4'h0, 6'h20, 16'h8200, 1'b1},
        {4'h8, 6'h00, 16'h0000, 1'b0},
        {4'h0, 6'h3F, 16'h03F0, 1'b0},
        {4'h0, 6'h2A, 16'h8080, 1'b1},
        {4'h6, 6'h15, 16'h8000, 1'b1}
    };

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [15:0] d);
        addr = a; wdata = d; wr = 1'b1;
        tick();
        wr = 1'b0; wdata = '0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [15:0] d);
        addr = a;
        #1;
        d = rdata;
    endtask

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        logic [15:0] d;
        @(negedge clk);
        tick();
        // R10 reset state
        chk("R10 irq", {15'd0, irq}, 16'h0);
        rd_reg(2'd0, d); chk("R10 status", d, 16'h0);
        rd_reg(2'd1, d); chk("R10 mask", d, 16'h0);
        rst_n = 1'b1;
        tick();
        chk("R10 irq after release", {15'd0, irq}, 16'h0);

        // vector table: R1 layout, R5/R6 masking and global gate
        for (int i = 0; i < 9; i++) begin
            logic [26:0] v;
            v = VEC[i];
            wr_reg(2'd0, 16'hFFFF);
            wr_reg(2'd1, v[16:1]);
            bank = v[26:23];
            src = v[22:17];
            tick();
            src = '0;
            repeat (3) tick();
            rd_reg(2'd0, d);
            chk($sformatf("R1 status vec%0d", i), d, {6'd0, v[22:17], v[26:23]});
            rd_reg(2'd1, d);
            chk($sformatf("R5 mask vec%0d", i), d, v[16:1] & 16'h83F0);
            chk($sformatf("R6 irq vec%0d", i), {15'd0, irq}, {15'd0, v[0]});
        end
        bank = '0;
        wr_reg(2'd0, 16'hFFFF);
        tick();

        // R2 bank bits live, write ignored
        bank = 4'h5;
        #1; rd_reg(2'd0, d); chk("R2 live bank", d, 16'h0005);
        wr_reg(2'd0, 16'h000F);
        rd_reg(2'd0, d); chk("R2 bank write ignored", d, 16'h0005);
        bank = 4'h0;
        #1; rd_reg(2'd0, d); chk("R2 bank cleared", d, 16'h0000);

        // R3 sticky, write 0 keeps, write 1 clears
        src = 6'h04; tick(); src = '0;
        wr_reg(2'd0, 16'h0000);
        rd_reg(2'd0, d); chk("R3 write0 keeps", d, 16'h0040);
        wr_reg(2'd0, 16'h0040);
        rd_reg(2'd0, d); chk("R3 write1 clears", d, 16'h0000);

        // R4 set wins over clear in the same cycle
        src = 6'h04; addr = 2'd0; wdata = 16'h0040; wr = 1'b1;
        tick();
        wr = 1'b0; src = '0;
        rd_reg(2'd0, d); chk("R4 set wins", d, 16'h0040);
        wr_reg(2'd0, 16'h0040);
        rd_reg(2'd0, d); chk("R4 later clear", d, 16'h0000);

        // R8 rise timing from idle, and fall timing
        wr_reg(2'd1, 16'h8030);
        src = 6'h01; tick(); src = '0;
        chk("R8 low after capture edge", {15'd0, irq}, 16'h0);
        tick();
        chk("R8 high on second edge", {15'd0, irq}, 16'h1);

        // R9 re-arm gap
        src = 6'h02; tick(); src = '0;
        chk("R9 still high", {15'd0, irq}, 16'h1);
        tick();
        chk("R9 gap low", {15'd0, irq}, 16'h0);
        tick();
        chk("R9 high again", {15'd0, irq}, 16'h1);

        // R7 falls when nothing enabled remains
        wr_reg(2'd0, 16'h0030);
        chk("R7 still high at clear edge", {15'd0, irq}, 16'h1);
        tick();
        chk("R7 low after clear", {15'd0, irq}, 16'h0);

        // R7 global enable cleared
        src = 6'h01; tick(); src = '0; tick();
        chk("R7 setup high", {15'd0, irq}, 16'h1);
        wr_reg(2'd1, 16'h0010);
        tick();
        chk("R7 global off low", {15'd0, irq}, 16'h0);
        rd_reg(2'd0, d); chk("R6 pending kept", d, 16'h0010);

        // R11 unused addresses
        wr_reg(2'd2, 16'hFFFF);
        wr_reg(2'd3, 16'hFFFF);
        rd_reg(2'd2, d); chk("R11 addr2 reads 0", d, 16'h0);
        rd_reg(2'd3, d); chk("R11 addr3 reads 0", d, 16'h0);
        rd_reg(2'd1, d); chk("R11 mask unchanged", d, 16'h0010);
        rd_reg(2'd0, d); chk("R11 status unchanged", d, 16'h0010);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule